// File: doc/BRIEF.md
# Non-Blocking Fault Reporting Queue

This block sits after the address-translation path of an I/O memory protection unit and takes one fault event per cycle. Every event gets a slave-error response on a response channel exactly one cycle later, whatever the state of the queue. The input has no ready signal, so a faulting device transaction is never held back. Non-recoverable faults also put a record into a circular buffer that software drains. Recoverable faults, the kind a device retries after asking for the page, get the error response and no record.

The ring holds a power-of-two number of slots. The block owns the tail pointer and software owns the head pointer. The ring counts as full when tail+1 equals head, so one slot always stays empty. A record that arrives while the ring is full is dropped, and a sticky overflow condition is recorded. That condition lives in a two-state machine. `ST_CLEAN` moves to `ST_OVERFLOWED` when a record is dropped. `ST_OVERFLOWED` goes back to `ST_CLEAN` on a write-one-to-clear pulse from software, but only when no record is dropped in that same cycle. A level interrupt stays high while the ring holds records or the machine is in `ST_OVERFLOWED`.

Top module: `fault_report_queue`

## Requirements
- R1: Each cycle with `flt_valid` high is followed in the next cycle by `rsp_valid` high, `rsp_code` = 2'b10 (slave error) and `rsp_dev` equal to the faulting device ID. `rsp_valid` is low in the cycle after any cycle without a fault.
- R2: A non-recoverable fault that arrives while the ring is not full writes its record into the slot at the current tail. The tail then advances by one, modulo DEPTH, at that clock edge.
- R3: A fault with `flt_recov` high writes no record, leaves the tail unchanged and still receives the response of R1.
- R4: Full means (tail+1) mod DEPTH == head, where head is the value registered before the edge. A non-recoverable fault that arrives while the ring is full is dropped, the tail stays unchanged and `ovf_flag` rises in the next cycle.
- R5: There is no back-pressure. Faults on consecutive cycles, including while the ring is full, each get their own response of R1.
- R6: `ovf_flag` stays set until an `ovf_clr` pulse clears it at the following edge. If a drop happens in the same cycle as the clear, the flag stays set.
- R7: `irq` is high exactly when tail != head or `ovf_flag` is set.
- R8: A record reads back through `rd_idx` as device ID, address, write bit and cause, each field on its own output.
- R9: After reset, tail = 0, head = 0, `ovf_flag` = 0, `irq` = 0 and `rsp_valid` = 0.
- R10: A `head_wr` pulse loads `head_val` into head at the next edge. The full test of R4 in that same cycle uses the old head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | Fault event present this cycle |
| flt_recov | input | 1 | Fault is recoverable: no record |
| flt_dev | input | DEV_W | Faulting device ID |
| flt_addr | input | ADDR_W | Faulting address |
| flt_write | input | 1 | 1 = write access, 0 = read |
| flt_cause | input | CAUSE_W | Cause code |
| rsp_valid | output | 1 | Error response strobe |
| rsp_code | output | 2 | Response code, 2'b10 = slave error |
| rsp_dev | output | DEV_W | Device the response is for |
| head_wr | input | 1 | Software head write strobe |
| head_val | input | PTR_W | New head value |
| ovf_clr | input | 1 | Write-one-to-clear pulse for overflow |
| rd_idx | input | PTR_W | Slot selected for readback |
| rd_dev | output | DEV_W | Device ID of selected record |
| rd_addr | output | ADDR_W | Address of selected record |
| rd_write | output | 1 | Write bit of selected record |
| rd_cause | output | CAUSE_W | Cause of selected record |
| tail_ptr | output | PTR_W | Tail pointer |
| head_ptr | output | PTR_W | Head pointer |
| ovf_flag | output | 1 | Sticky overflow |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume nothing about the fault inputs. Any pattern of valid and recoverable bits, in any cycle, is legal. Software may write any head value, so the full test can land on any tail and head pair. For that reason the stimulus sweeps every head position, with many recoverable/non-recoverable mixes and back-to-back bursts longer than the ring.

// File: rtl/frq_pkg.sv
package frq_pkg;
    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_SLVERR = 2'b10
    } resp_e;

    typedef enum logic {
        ST_CLEAN      = 1'b0,
        ST_OVERFLOWED = 1'b1
    } ovf_state_e;
endpackage

// File: rtl/frq_resp.sv
module frq_resp
    import frq_pkg::*;
#(
    parameter int DEV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flt_valid,
    input  logic [DEV_W-1:0] flt_dev,
    output logic             rsp_valid,
    output logic [1:0]       rsp_code,
    output logic [DEV_W-1:0] rsp_dev
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RESP_OKAY;
            rsp_dev   <= '0;
        end else begin
            rsp_valid <= flt_valid;
            if (flt_valid) begin
                rsp_code <= RESP_SLVERR;
                rsp_dev  <= flt_dev;
            end
        end
    end

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> (rsp_valid && rsp_code == RESP_SLVERR)); // R1
    AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_valid |=> !rsp_valid); // R1
endmodule

// File: rtl/frq_ring.sv
module frq_ring #(
    parameter int DEPTH   = 4,
    parameter int DEV_W   = 4,
    parameter int ADDR_W  = 16,
    parameter int CAUSE_W = 4,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int REC_W  = DEV_W + ADDR_W + 1 + CAUSE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_req,
    input  logic [REC_W-1:0]   push_rec,
    input  logic               head_wr,
    input  logic [PTR_W-1:0]   head_val,
    input  logic [PTR_W-1:0]   rd_idx,
    output logic [REC_W-1:0]   rd_rec,
    output logic [PTR_W-1:0]   tail,
    output logic [PTR_W-1:0]   head,
    output logic               drop,
    output logic               nonempty
);
    logic [REC_W-1:0] slots [DEPTH];
    logic             full;

    assign full     = (PTR_W'(tail + 1'b1) == head);
    assign drop     = push_req && full;
    assign nonempty = (tail != head);
    assign rd_rec   = slots[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail <= '0;
            head <= '0;
        end else begin
            if (push_req && !full) tail <= PTR_W'(tail + 1'b1);
            if (head_wr)           head <= head_val;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_req && !full && tail == PTR_W'(g)) slots[g] <= push_rec;
        end
    end

    AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !full) |=> tail == PTR_W'($past(tail) + 1'b1)); // R2
    AST_TAIL_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full) |=> $stable(tail)); // R4
    AST_TAIL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !push_req |=> $stable(tail)); // R3
endmodule

// File: rtl/frq_ctrl.sv
module frq_ctrl
    import frq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic drop,
    input  logic clr,
    input  logic nonempty,
    output logic ovf_flag,
    output logic irq
);
    ovf_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAN:      if (drop)        state_d = ST_OVERFLOWED;
            ST_OVERFLOWED: if (clr && !drop) state_d = ST_CLEAN;
            default:                         state_d = ST_CLEAN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_OVERFLOWED: ovf_flag = 1'b1;
            default:       ovf_flag = 1'b0;
        endcase
        irq = ovf_flag || nonempty;
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr) |=> ovf_flag); // R6
    AST_DROP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> ovf_flag); // R4
    AST_IRQ_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> irq); // R7
endmodule

// File: rtl/fault_report_queue.sv
module fault_report_queue #(
    parameter int DEPTH   = 4,
    parameter int DEV_W   = 4,
    parameter int ADDR_W  = 16,
    parameter int CAUSE_W = 4,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int REC_W  = DEV_W + ADDR_W + 1 + CAUSE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flt_valid,
    input  logic               flt_recov,
    input  logic [DEV_W-1:0]   flt_dev,
    input  logic [ADDR_W-1:0]  flt_addr,
    input  logic               flt_write,
    input  logic [CAUSE_W-1:0] flt_cause,
    output logic               rsp_valid,
    output logic [1:0]         rsp_code,
    output logic [DEV_W-1:0]   rsp_dev,
    input  logic               head_wr,
    input  logic [PTR_W-1:0]   head_val,
    input  logic               ovf_clr,
    input  logic [PTR_W-1:0]   rd_idx,
    output logic [DEV_W-1:0]   rd_dev,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic               rd_write,
    output logic [CAUSE_W-1:0] rd_cause,
    output logic [PTR_W-1:0]   tail_ptr,
    output logic [PTR_W-1:0]   head_ptr,
    output logic               ovf_flag,
    output logic               irq
);
    logic             push_req;
    logic             drop;
    logic             nonempty;
    logic [REC_W-1:0] push_rec;
    logic [REC_W-1:0] rd_rec;

    assign push_req = flt_valid && !flt_recov;
    assign push_rec = {flt_dev, flt_addr, flt_write, flt_cause};
    assign {rd_dev, rd_addr, rd_write, rd_cause} = rd_rec;

    frq_resp #(.DEV_W(DEV_W)) u_resp (
        .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_dev(flt_dev),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_dev(rsp_dev)
    );

    frq_ring #(.DEPTH(DEPTH), .DEV_W(DEV_W), .ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W)) u_ring (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_rec(push_rec),
        .head_wr(head_wr), .head_val(head_val), .rd_idx(rd_idx), .rd_rec(rd_rec),
        .tail(tail_ptr), .head(head_ptr), .drop(drop), .nonempty(nonempty)
    );

    frq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .drop(drop), .clr(ovf_clr),
        .nonempty(nonempty), .ovf_flag(ovf_flag), .irq(irq)
    );

    AST_NO_STALL_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && drop) |=> rsp_valid); // R5
endmodule

// File: tb/fault_report_queue_tb.sv
module fault_report_queue_tb;
    localparam int CLK_PERIOD = 10;
    localparam int D    = 4;
    localparam int PW   = 2;
    localparam int DW   = 4;
    localparam int AW   = 16;
    localparam int CW   = 4;

    logic clk = 0;
    logic rst_n = 0;
    logic flt_valid = 0, flt_recov = 0, flt_write = 0;
    logic [DW-1:0] flt_dev = 0;
    logic [AW-1:0] flt_addr = 0;
    logic [CW-1:0] flt_cause = 0;
    logic rsp_valid;
    logic [1:0] rsp_code;
    logic [DW-1:0] rsp_dev;
    logic head_wr = 0, ovf_clr = 0;
    logic [PW-1:0] head_val = 0, rd_idx = 0;
    logic [DW-1:0] rd_dev;
    logic [AW-1:0] rd_addr;
    logic rd_write;
    logic [CW-1:0] rd_cause;
    logic [PW-1:0] tail_ptr, head_ptr;
    logic ovf_flag, irq;

    int n_chk = 0, n_err = 0;
    int m_tail = 0, m_head = 0;
    bit m_ovf = 0;
    logic [DW-1:0] m_dev [D];
    logic [AW-1:0] m_addr [D];
    bit            m_wr [D];
    logic [CW-1:0] m_cause [D];

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_report_queue #(.DEPTH(D), .DEV_W(DW), .ADDR_W(AW), .CAUSE_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_recov(flt_recov),
        .flt_dev(flt_dev), .flt_addr(flt_addr), .flt_write(flt_write), .flt_cause(flt_cause),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_dev(rsp_dev),
        .head_wr(head_wr), .head_val(head_val), .ovf_clr(ovf_clr), .rd_idx(rd_idx),
        .rd_dev(rd_dev), .rd_addr(rd_addr), .rd_write(rd_write), .rd_cause(rd_cause),
        .tail_ptr(tail_ptr), .head_ptr(head_ptr), .ovf_flag(ovf_flag), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_state(input string ctx);
        check(int'(tail_ptr) == m_tail, {"R2 tail ", ctx}, tail_ptr, m_tail);
        check(int'(head_ptr) == m_head, {"R10 head ", ctx}, head_ptr, m_head);
        check(ovf_flag == m_ovf, {"R6 ovf ", ctx}, ovf_flag, m_ovf);
        check(irq == ((m_tail != m_head) || m_ovf), {"R7 irq ", ctx}, irq,
              (m_tail != m_head) || m_ovf);
    endtask

    // One clock: drive inputs, advance, update model, check outputs.
    task automatic step(input bit fv, input bit rec, input int dev, input int addr,
                        input bit wr, input int cause, input bit hw, input int hv,
                        input bit clr);
        bit full;
        flt_valid = fv; flt_recov = rec; flt_dev = DW'(dev); flt_addr = AW'(addr);
        flt_write = wr; flt_cause = CW'(cause); head_wr = hw; head_val = PW'(hv);
        ovf_clr = clr;
        @(posedge clk); #1;
        full = (((m_tail + 1) % D) == m_head);
        if (fv && !rec) begin
            if (!full) begin
                m_dev[m_tail] = DW'(dev); m_addr[m_tail] = AW'(addr);
                m_wr[m_tail] = wr; m_cause[m_tail] = CW'(cause);
                m_tail = (m_tail + 1) % D;
            end else begin
                m_ovf = 1;
            end
        end
        if (clr && !(fv && !rec && full)) m_ovf = 0;
        if (hw) m_head = hv % D;
        check(rsp_valid == fv, "R1 rsp_valid", rsp_valid, fv);
        if (fv) begin
            check(rsp_code == 2'b10, "R1 rsp_code", rsp_code, 2);
            check(int'(rsp_dev) == (dev % (1 << DW)), "R5 rsp_dev", rsp_dev, dev % (1 << DW));
        end
        check_state(rec ? "R3" : "R4");
        flt_valid = 0; head_wr = 0; ovf_clr = 0;
    endtask

    task automatic check_records();
        for (int p = m_head; p != m_tail; p = (p + 1) % D) begin
            rd_idx = PW'(p); #1;
            check(rd_dev == m_dev[p], "R8 dev", rd_dev, m_dev[p]);
            check(rd_addr == m_addr[p], "R8 addr", rd_addr, m_addr[p]);
            check(rd_write == m_wr[p], "R8 write", rd_write, m_wr[p]);
            check(rd_cause == m_cause[p], "R8 cause", rd_cause, m_cause[p]);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        // R9 reset state
        check(tail_ptr == 0 && head_ptr == 0, "R9 ptrs", tail_ptr, 0);
        check(!ovf_flag && !irq && !rsp_valid, "R9 flags", {ovf_flag, irq, rsp_valid}, 0);

        // Sweep head positions and recoverable mixes with bursts longer than the ring
        for (int h = 0; h < D; h++) begin
            for (int pat = 0; pat < 16; pat++) begin
                step(0, 0, 0, 0, 0, 0, 1, h, 1);
                for (int i = 0; i < 5; i++)
                    step(1, pat[i % 4], i + pat, (h << 12) ^ (pat << 4) ^ i,
                         i[0], pat ^ i, 0, 0, 0);
                check_records();
                step(0, 0, 0, 0, 0, 0, 0, 0, 0);
            end
        end

        // R6: clear in the same cycle as a drop keeps the flag; plain clear drops it
        step(0, 0, 0, 0, 0, 0, 1, (m_tail + 1) % D, 0);
        step(1, 0, 3, 16'h1234, 1, 5, 0, 0, 0);
        step(1, 0, 4, 16'h4321, 0, 6, 0, 0, 1);
        check(ovf_flag == 1, "R6 set wins over clear", ovf_flag, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);
        check(ovf_flag == 1, "R6 sticky idle", ovf_flag, 1);
        step(0, 0, 0, 0, 0, 0, 1, m_tail, 1);
        check(!ovf_flag && !irq, "R7 irq low when empty and clear", irq, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule